// File: doc/BRIEF.md
# Nibble-Command Register Access Port

This block gives a host on the far side of a byte stream access to a small device register file. Each incoming command byte holds an opcode in its upper four bits and a four-bit payload in its lower four bits. The host builds an 8-bit register address from two nibble commands. It builds 8-bit write data from two more nibble commands. The write takes effect only when the high data nibble arrives.

A read command returns the selected register on a valid/ready response stream. A variant of the read command also steps the address forward, so the host can fetch a run of neighbouring registers, such as a multi-byte counter, without setting the address again. Register 0 holds a fixed identification value. Every other register in range is writable storage, and register 1 serves as the link-test scratch location. While a response byte waits to be taken, the command input stalls.

Top module: `nibreg_port`

## Requirements
- R1: Command byte bits [7:4] hold the opcode and bits [3:0] the payload. Opcode 0x0 loads the payload into address bits [3:0] and opcode 0x1 loads it into address bits [7:4]. Each leaves the other address half unchanged.
- R2: Opcode 0x2 stores the payload as a pending low data nibble and writes nothing. Opcode 0x3 writes {payload, pending nibble} into the addressed register and does not change the address. Repeated 0x2/0x3 pairs after one address setup each write the same register again.
- R3: Opcode 0x4 (read) presents the addressed register's content on rsp_byte, with rsp_valid high, in the cycle after the command is accepted. Exactly one byte is returned per read.
- R4: Opcode 0x5 (read with increment, bit 4 being the increment flag) returns a byte like 0x4 and then adds one to the address, wrapping from 0xFF to 0x00. Six such reads return six consecutive registers in address order.
- R5: The register at address 0 always reads 0xA6, and writes to it are ignored.
- R6: A writable register (scratch at address 1) reads back the last value written to it, for example 0x55 and then 0xAA.
- R7: Addresses at or above NUM_REGS (16) read as 0x00. Writes to them are ignored and do not alias onto any in-range register.
- R8: Opcodes 0x6 to 0xF are accepted and have no effect on the address, the pending nibble, the registers or the response stream.
- R9: While rsp_valid is high and rsp_ready is low, cmd_ready stays low and rsp_byte stays stable. cmd_ready returns high in the cycle after the response is taken.
- R10: Synchronous active-high reset clears the address to 0x00, the pending data nibble to 0 and all writable registers to 0x00, and drops rsp_valid. The identification value is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command byte available |
| cmd_ready | output | 1 | Block accepts a command this cycle |
| cmd_byte | input | 8 | Opcode [7:4] and payload [3:0] |
| rsp_valid | output | 1 | Response byte available |
| rsp_ready | input | 1 | Consumer takes the response byte |
| rsp_byte | output | 8 | Register content returned by a read |

## Verification
The bench uses the default parameters: 16 registers, the identification register at address 0 and the value 0xA6. With only 16 registers in an 8-bit address space, setting a high address nibble of 1 or 2 reaches out-of-range addresses that share their low bits with real registers, which exposes aliasing. A single incrementing read at 0xFF reaches the wrap back to the identification register. The small file also lets six incrementing reads cross a run of stored counter bytes and step one past it.

// File: rtl/nibreg_pkg.sv
package nibreg_pkg;

    typedef enum logic [3:0] {
        OP_ADDR_LO  = 4'h0,
        OP_ADDR_HI  = 4'h1,
        OP_DATA_LO  = 4'h2,
        OP_DATA_WR  = 4'h3,
        OP_READ     = 4'h4,
        OP_READ_INC = 4'h5
    } op_e;

    // bit of the command byte that requests address increment on a read
    localparam int INC_FLAG_BIT = 4;

    typedef struct packed {
        logic       addr_lo;
        logic       addr_hi;
        logic       data_lo;
        logic       data_wr;
        logic       rd;
        logic       inc;
        logic [3:0] nib;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [7:0] b, input logic fire);
        cmd_t c;
        c     = '0;
        c.nib = b[3:0];
        if (fire) begin
            case (b[7:4])
                OP_ADDR_LO:  c.addr_lo = 1'b1;
                OP_ADDR_HI:  c.addr_hi = 1'b1;
                OP_DATA_LO:  c.data_lo = 1'b1;
                OP_DATA_WR:  c.data_wr = 1'b1;
                OP_READ, OP_READ_INC: begin
                    c.rd  = 1'b1;
                    c.inc = b[INC_FLAG_BIT];
                end
                default: ;
            endcase
        end
        return c;
    endfunction

    function automatic logic [7:0] join_nibbles(input logic [3:0] hi, input logic [3:0] lo);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/nibreg_decode.sv
module nibreg_decode
    import nibreg_pkg::*;
(
    input  logic [7:0] cmd_byte,
    input  logic       fire,
    output cmd_t       cmd
);
    always_comb cmd = decode_cmd(cmd_byte, fire);
endmodule

// File: rtl/nibreg_ptr.sv
module nibreg_ptr
    import nibreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cmd_t       cmd,
    output logic [7:0] addr,
    output logic [3:0] hold
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
            hold <= '0;
        end else begin
            if (cmd.addr_lo) addr[3:0] <= cmd.nib;
            if (cmd.addr_hi) addr[7:4] <= cmd.nib;
            if (cmd.data_lo) hold <= cmd.nib;
            if (cmd.rd && cmd.inc) addr <= addr + 8'd1;
        end
    end

    // R4: incrementing read steps the pointer by one (with wrap)
    a_r4_read_inc_steps: assert property (@(posedge clk) disable iff (rst)
        (cmd.rd && cmd.inc) |=> (addr == $past(addr) + 8'd1));

    // R2: committing a write leaves the pointer in place
    a_r2_write_keeps_addr: assert property (@(posedge clk) disable iff (rst)
        cmd.data_wr |=> $stable(addr));
endmodule

// File: rtl/nibreg_bank.sv
module nibreg_bank #(
    parameter int         NUM_REGS = 16,
    parameter int         ID_ADDR  = 0,
    parameter logic [7:0] ID_VALUE = 8'hA6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] addr,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data
);
    localparam logic [8:0] LIMIT = 9'(NUM_REGS);

    logic [7:0] regs [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (i == ID_ADDR) begin : g_id
            assign regs[i] = ID_VALUE;
        end else begin : g_rw
            always_ff @(posedge clk) begin
                if (rst)
                    regs[i] <= '0;
                else if (wr_en && addr == 8'(i))
                    regs[i] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (addr == 8'(i)) rd_data = regs[i];
    end

    // R6: a write to an in-range writable register is visible on the next read
    a_r6_write_visible: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ({1'b0, addr} < LIMIT) && addr != 8'(ID_ADDR))
        |=> (rd_data == $past(wr_data)));
endmodule

// File: rtl/nibreg_port.sv
module nibreg_port
    import nibreg_pkg::*;
#(
    parameter int         NUM_REGS = 16,
    parameter int         ID_ADDR  = 0,
    parameter logic [7:0] ID_VALUE = 8'hA6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    input  logic [7:0] cmd_byte,
    output logic       rsp_valid,
    input  logic       rsp_ready,
    output logic [7:0] rsp_byte
);
    cmd_t       cmd;
    logic       fire;
    logic [7:0] addr;
    logic [3:0] hold;
    logic [7:0] rd_data;

    assign cmd_ready = !rsp_valid;
    assign fire      = cmd_valid && cmd_ready;

    nibreg_decode i_decode (
        .cmd_byte (cmd_byte),
        .fire     (fire),
        .cmd      (cmd)
    );

    nibreg_ptr i_ptr (
        .clk  (clk),
        .rst  (rst),
        .cmd  (cmd),
        .addr (addr),
        .hold (hold)
    );

    nibreg_bank #(
        .NUM_REGS (NUM_REGS),
        .ID_ADDR  (ID_ADDR),
        .ID_VALUE (ID_VALUE)
    ) i_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cmd.data_wr),
        .addr    (addr),
        .wr_data (join_nibbles(cmd.nib, hold)),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_byte  <= '0;
        end else if (cmd.rd) begin
            rsp_valid <= 1'b1;
            rsp_byte  <= rd_data;
        end else if (rsp_valid && rsp_ready) begin
            rsp_valid <= 1'b0;
        end
    end

    // R3: an accepted read raises the response in the following cycle
    a_r3_read_responds: assert property (@(posedge clk) disable iff (rst)
        cmd.rd |=> rsp_valid);

    // R9: a pending, untaken response holds its byte
    a_r9_rsp_held: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_byte)));

    // R5: reading the identification address yields the fixed value
    a_r5_id_readback: assert property (@(posedge clk) disable iff (rst)
        (cmd.rd && addr == 8'(ID_ADDR)) |=> (rsp_byte == ID_VALUE));

    // R8: unused opcodes leave pointer and pending nibble untouched
    a_r8_unused_no_effect: assert property (@(posedge clk) disable iff (rst)
        (fire && cmd_byte[7:4] >= 4'h6) |=> ($stable(addr) && $stable(hold)));
endmodule

// File: tb/test_nibreg_port.sv
module test_nibreg_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [7:0] cmd_byte = '0;
    logic       rsp_valid;
    logic       rsp_ready = 1'b1;
    logic [7:0] rsp_byte;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    nibreg_port i_nibreg_port (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_byte  (cmd_byte),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_byte  (rsp_byte)
    );

    // {expect response, command byte, expected byte}
    localparam int NV = 64;
    localparam logic [16:0] VEC [NV] = '{
        // R5 identification read
        {1'b0,8'h00,8'h00}, {1'b0,8'h10,8'h00}, {1'b1,8'h40,8'hA6},
        // R6 scratch 0x55 then 0xAA
        {1'b0,8'h01,8'h00}, {1'b0,8'h10,8'h00}, {1'b0,8'h25,8'h00}, {1'b0,8'h35,8'h00},
        {1'b1,8'h40,8'h55}, {1'b0,8'h2A,8'h00}, {1'b0,8'h3A,8'h00}, {1'b1,8'h40,8'hAA},
        // R5 write to identification ignored
        {1'b0,8'h00,8'h00}, {1'b0,8'h10,8'h00}, {1'b0,8'h23,8'h00}, {1'b0,8'h31,8'h00},
        {1'b1,8'h40,8'hA6},
        // R2 two pairs to one address, last wins
        {1'b0,8'h02,8'h00}, {1'b0,8'h10,8'h00}, {1'b0,8'h21,8'h00}, {1'b0,8'h32,8'h00},
        {1'b0,8'h23,8'h00}, {1'b0,8'h34,8'h00}, {1'b1,8'h40,8'h43},
        // R1/R2 fill registers 4..9 with 0x11..0x66
        {1'b0,8'h04,8'h00}, {1'b0,8'h21,8'h00}, {1'b0,8'h31,8'h00},
        {1'b0,8'h05,8'h00}, {1'b0,8'h22,8'h00}, {1'b0,8'h32,8'h00},
        {1'b0,8'h06,8'h00}, {1'b0,8'h23,8'h00}, {1'b0,8'h33,8'h00},
        {1'b0,8'h07,8'h00}, {1'b0,8'h24,8'h00}, {1'b0,8'h34,8'h00},
        {1'b0,8'h08,8'h00}, {1'b0,8'h25,8'h00}, {1'b0,8'h35,8'h00},
        {1'b0,8'h09,8'h00}, {1'b0,8'h26,8'h00}, {1'b0,8'h36,8'h00},
        // R4 six incrementing reads, then plain read at 10
        {1'b0,8'h04,8'h00}, {1'b1,8'h50,8'h11}, {1'b1,8'h50,8'h22}, {1'b1,8'h50,8'h33},
        {1'b1,8'h50,8'h44}, {1'b1,8'h50,8'h55}, {1'b1,8'h50,8'h66}, {1'b1,8'h40,8'h00},
        // R7 out of range 0x21: write ignored, reads zero, no alias on 0x01
        {1'b0,8'h01,8'h00}, {1'b0,8'h12,8'h00}, {1'b0,8'h2F,8'h00}, {1'b0,8'h3F,8'h00},
        {1'b1,8'h40,8'h00}, {1'b0,8'h10,8'h00}, {1'b1,8'h40,8'hAA},
        // R8 unused opcodes
        {1'b0,8'h9C,8'h00}, {1'b0,8'hF3,8'h00}, {1'b0,8'h6A,8'h00}, {1'b1,8'h40,8'hAA},
        // R4 wrap from 0xFF to 0x00
        {1'b0,8'h0F,8'h00}, {1'b0,8'h1F,8'h00}, {1'b1,8'h50,8'h00}, {1'b1,8'h40,8'hA6}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_byte  = b;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string req, input logic [7:0] exp);
        @(negedge clk);
        check({req, " rsp_valid"}, {7'd0, rsp_valid}, 8'd1);
        check(req, rsp_byte, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        do_reset();
        // R10 state right after reset
        check("R10 rsp_valid", {7'd0, rsp_valid}, 8'd0);
        check("R10 cmd_ready", {7'd0, cmd_ready}, 8'd1);
        send(8'h40);
        expect_rsp("R10 addr zero reads id", 8'hA6);
        send(8'h01);
        send(8'h40);
        expect_rsp("R10 scratch cleared", 8'h00);
        send(8'h00);

        for (int k = 0; k < NV; k++) begin
            send(VEC[k][15:8]);
            if (VEC[k][16]) expect_rsp($sformatf("R1-vector %0d (R3)", k), VEC[k][7:0]);
        end

        // R9 stall while response not taken
        send(8'h01);
        rsp_ready = 1'b0;
        send(8'h40);
        @(negedge clk);
        check("R9 rsp_valid pending", {7'd0, rsp_valid}, 8'd1);
        check("R9 cmd_ready low", {7'd0, cmd_ready}, 8'd0);
        repeat (3) @(negedge clk);
        check("R9 still pending", {7'd0, rsp_valid}, 8'd1);
        check("R9 still stalled", {7'd0, cmd_ready}, 8'd0);
        check("R9 byte held", rsp_byte, 8'hAA);
        rsp_ready = 1'b1;
        @(negedge clk);
        check("R9 released rsp", {7'd0, rsp_valid}, 8'd0);
        check("R9 released cmd", {7'd0, cmd_ready}, 8'd1);

        // R10 reset clears pending nibble and registers
        send(8'h2C);
        do_reset();
        send(8'h35);
        send(8'h40);
        expect_rsp("R10 addr and hold cleared", 8'hA6);
        send(8'h01);
        send(8'h40);
        expect_rsp("R10 scratch after reset", 8'h00);
        send(8'h37);
        send(8'h40);
        expect_rsp("R10 hold zero on write", 8'h70);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule